// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers 32 interrupt request lines and presents them to a processor through two banks of per-line controls. The first bank drives the normal interrupt line `irq_o`. The second bank drives the fast interrupt line `fiq_o`. Each bank holds its own enable, trigger-kind and trigger-sense settings for every line. In edge mode each line keeps a sticky pending bit, and software clears that bit by writing a one to it. A status word shows the lines that are both pending and enabled. Software reads it and then services each set bit.

All registers sit on a simple single-cycle port. The port carries a write strobe, a word address and write data, and it returns read data combinationally. The word address is the byte offset divided by four. Source `n` always maps to bit `n` of every register. Address bit 3 picks the bank. A read-only word in the normal bank returns the index of the lowest pending normal interrupt, which saves software a bit scan. The `src_in` lines are assumed to be synchronous to `clk`.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset, every mask, mode, sense and pending bit is 0, `irq_o` and `fiq_o` are low, and the lowest-index word reads 0x8000_0000.
- R2: The normal bank uses byte offsets raw 0x00, mask 0x04, clear 0x08, mode 0x0C, sense 0x10 and status 0x14. The fast bank uses the same words plus 0x20. The raw word returns `src_in` as it was registered on the previous clock.
- R3: A mask bit of 1 enables its source and 0 blocks it. The mask word reads back exactly what was written.
- R4: With mode bit 0 (level), the line is pending while the registered input is 1 (sense 0) or 0 (sense 1). Writes to the clear word have no effect on such a line.
- R5: With mode bit 1 (edge), a 0-to-1 input change (sense 0) or a 1-to-0 change (sense 1) sets a pending bit. That bit stays set until it is cleared. A change in the opposite direction sets nothing.
- R6: Writing 1 to bit n of the clear word clears the edge pending bit n of that bank only, and bits written 0 are untouched. An edge that arrives in the same cycle as its clear leaves the bit pending. The clear word reads 0.
- R7: The status word equals pending AND mask. Edge pending bits latch even while masked and appear in status once unmasked. Writes to the raw, status and lowest-index words change nothing.
- R8: `irq_o` is the OR of the normal status bits and `fiq_o` is the OR of the fast status bits, each registered. An input change sampled at clock edge k shows in status after edge k and on the line after edge k+1.
- R9: The two banks are independent. Settings, pending bits and clears in one bank never affect the other bank.
- R10: Byte offset 0x18 reads the index of the lowest set normal status bit in bits 4:0, with the other bits 0. It reads 0x8000_0000 when no normal status bit is set. Offsets 0x38 and 0x3C read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Interrupt request lines, synchronous to clk |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_waddr | input | 4 | Word address (byte offset bits 5:2); bit 3 selects the fast bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_waddr, combinational |
| irq_o | output | 1 | Registered normal interrupt line |
| fiq_o | output | 1 | Registered fast interrupt line |

## Verification
The assertions check several properties on every cycle. Each interrupt line must equal the OR of its bank's status from the previous cycle. An edge pending bit must never drop unless a clear write hit it or its line left edge mode. The lowest-index word must always name a set status bit with no set bit below it, or report none.

Only the bench scenarios can show the rest, because it depends on chosen input sequences:
- which input directions count as an edge for each sense setting;
- that level lines ignore clears;
- that an edge wins over a clear in the same cycle;
- that read-only words ignore writes;
- that the banks stay apart.

The per-cycle reference model covers the read port and both lines throughout.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NBANK     = 2;
  localparam int unsigned SEL_BITS  = 3;
  localparam int unsigned BANK_BITS = $clog2(NBANK);
  localparam int unsigned ADDR_W    = SEL_BITS + BANK_BITS;

  localparam logic [WORD_W-1:0] NONE_PENDING = {1'b1, {(WORD_W-1){1'b0}}};

  // word selector inside one bank (offset / 4)
  typedef enum logic [SEL_BITS-1:0] {
    W_RAW   = 3'd0,
    W_MASK  = 3'd1,
    W_CLEAR = 3'd2,
    W_MODE  = 3'd3,
    W_SENSE = 3'd4,
    W_STAT  = 3'd5,
    W_FIRST = 3'd6,
    W_NONE  = 3'd7
  } word_sel_e;

  // edge event for one line: rising when fall_sel is 0, falling when 1
  function automatic logic edge_hit(input logic now_v, input logic prev_v,
                                    input logic fall_sel);
    return fall_sel ? (prev_v & ~now_v) : (now_v & ~prev_v);
  endfunction

  // level qualification for one line: active high when low_sel is 0
  function automatic logic level_hit(input logic now_v, input logic low_sel);
    return now_v ^ low_sel;
  endfunction

  // lowest set bit index, or NONE_PENDING when the vector is empty
  function automatic logic [WORD_W-1:0] first_word(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    r = NONE_PENDING;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (v[i]) r = WORD_W'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/intc_trigger.sv
module intc_trigger
  import intc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_now,
  input  logic [NSRC-1:0] src_prev,
  input  logic [NSRC-1:0] edge_mode,
  input  logic [NSRC-1:0] sense,
  input  logic [NSRC-1:0] clr_hit,
  output logic [NSRC-1:0] pend
);

  logic [NSRC-1:0] edge_ev;
  logic [NSRC-1:0] lvl_act;
  logic [NSRC-1:0] latch_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_line
    assign edge_ev[i] = edge_hit(src_now[i], src_prev[i], sense[i]);
    assign lvl_act[i] = level_hit(src_prev[i], sense[i]);
    assign pend[i]    = edge_mode[i] ? latch_q[i] : lvl_act[i];
  end

  // a new edge wins over a clear in the same cycle; level lines hold no latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= edge_mode & ((latch_q & ~clr_hit) | edge_ev);
  end

endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  word_sel_e         sel,
  input  logic [NSRC-1:0]   wdata,
  input  logic [NSRC-1:0]   src_now,
  input  logic [NSRC-1:0]   src_q,
  output logic [NSRC-1:0]   stat,
  output logic [NSRC-1:0]   pend,
  output logic [NSRC-1:0]   mode,
  output logic [NSRC-1:0]   clr_hit,
  output logic [WORD_W-1:0] rdat
);

  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] mode_q;
  logic [NSRC-1:0] sense_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      mode_q  <= '0;
      sense_q <= '0;
    end else if (wr_en) begin
      case (sel)
        W_MASK:  mask_q  <= wdata;
        W_MODE:  mode_q  <= wdata;
        W_SENSE: sense_q <= wdata;
        default: ;
      endcase
    end
  end

  assign clr_hit = (wr_en && sel == W_CLEAR) ? wdata : '0;

  intc_trigger #(.NSRC(NSRC)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_now  (src_now),
    .src_prev (src_q),
    .edge_mode(mode_q),
    .sense    (sense_q),
    .clr_hit  (clr_hit),
    .pend     (pend)
  );

  assign stat = pend & mask_q;
  assign mode = mode_q;

  always_comb begin
    case (sel)
      W_RAW:   rdat = WORD_W'(src_q);
      W_MASK:  rdat = WORD_W'(mask_q);
      W_MODE:  rdat = WORD_W'(mode_q);
      W_SENSE: rdat = WORD_W'(sense_q);
      W_STAT:  rdat = WORD_W'(stat);
      default: rdat = '0;
    endcase
  end

endmodule

// File: rtl/intc_first.sv
module intc_first
  import intc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic [NSRC-1:0]   stat,
  output logic [WORD_W-1:0] first
);

  assign first = first_word(WORD_W'(stat));

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);

  logic [NSRC-1:0]      src_q;
  logic [NSRC-1:0]      stat_a [NBANK];
  logic [NSRC-1:0]      pend_a [NBANK];
  logic [NSRC-1:0]      mode_a [NBANK];
  logic [NSRC-1:0]      clr_a  [NBANK];
  logic [WORD_W-1:0]    rdat_a [NBANK];
  logic [NBANK-1:0]     line_q;
  logic [BANK_BITS-1:0] bank_sel;
  word_sel_e            word_sel;
  logic [WORD_W-1:0]    first_w;

  // named internal events for the checker
  logic [NSRC-1:0] irq_stat_w, fiq_stat_w;
  logic [NSRC-1:0] pend0_w, pend1_w, mode0_w, mode1_w, clr0_w, clr1_w;

  assign bank_sel = bus_waddr[ADDR_W-1:SEL_BITS];
  assign word_sel = word_sel_e'(bus_waddr[SEL_BITS-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_in;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    intc_bank #(.NSRC(NSRC)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr && (bank_sel == BANK_BITS'(b))),
      .sel    (word_sel),
      .wdata  (bus_wdata[NSRC-1:0]),
      .src_now(src_in),
      .src_q  (src_q),
      .stat   (stat_a[b]),
      .pend   (pend_a[b]),
      .mode   (mode_a[b]),
      .clr_hit(clr_a[b]),
      .rdat   (rdat_a[b])
    );
  end

  intc_first #(.NSRC(NSRC)) u_first (
    .stat (stat_a[0]),
    .first(first_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else begin
      for (int b = 0; b < NBANK; b++) line_q[b] <= |stat_a[b];
    end
  end

  assign irq_o = line_q[0];
  assign fiq_o = line_q[1];

  assign bus_rdata = (bank_sel == '0 && word_sel == W_FIRST) ? first_w : rdat_a[bank_sel];

  assign irq_stat_w = stat_a[0];
  assign fiq_stat_w = stat_a[1];
  assign pend0_w    = pend_a[0];
  assign pend1_w    = pend_a[1];
  assign mode0_w    = mode_a[0];
  assign mode1_w    = mode_a[1];
  assign clr0_w     = clr_a[0];
  assign clr1_w     = clr_a[1];

endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int unsigned NSRC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_o,
  input logic            fiq_o,
  input logic [NSRC-1:0] irq_stat,
  input logic [NSRC-1:0] fiq_stat,
  input logic [NSRC-1:0] pend0,
  input logic [NSRC-1:0] pend1,
  input logic [NSRC-1:0] mode0,
  input logic [NSRC-1:0] mode1,
  input logic [NSRC-1:0] clr0,
  input logic [NSRC-1:0] clr1,
  input logic [31:0]     first_w
);

  localparam int unsigned IDXW = $clog2(NSRC);

  // R8
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|$past(irq_stat)));

  // R8
  fiq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == (|$past(fiq_stat)));

  // R5
  edge_hold_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend0) & $past(mode0) & mode0 & ~$past(clr0)) & ~pend0) == '0);

  // R5
  edge_hold_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend1) & $past(mode1) & mode1 & ~$past(clr1)) & ~pend1) == '0);

  // R10
  first_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat == '0) |-> (first_w == 32'h8000_0000));

  // R10
  first_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat != '0) |-> (irq_stat[first_w[IDXW-1:0]] &&
      ((irq_stat & ((NSRC'(1) << first_w[IDXW-1:0]) - NSRC'(1))) == '0)));

endmodule

bind dual_bank_intc intc_chk #(.NSRC(NSRC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_o   (irq_o),
  .fiq_o   (fiq_o),
  .irq_stat(irq_stat_w),
  .fiq_stat(fiq_stat_w),
  .pend0   (pend0_w),
  .pend1   (pend1_w),
  .mode0   (mode0_w),
  .mode1   (mode1_w),
  .clr0    (clr0_w),
  .clr1    (clr1_w),
  .first_w (first_w)
);

// File: tb/sim_dual_bank_intc.sv
`timescale 1ns/1ps
module sim_dual_bank_intc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_bank_intc u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_srcq;
  logic [31:0] m_mask [2];
  logic [31:0] m_mode [2];
  logic [31:0] m_sense [2];
  logic [31:0] m_latch [2];
  bit          m_line [2];

  function automatic bit m_pend(int b, int i);
    if (m_mode[b][i]) return m_latch[b][i];
    if (m_sense[b][i]) return !m_srcq[i];
    return m_srcq[i];
  endfunction

  function automatic logic [31:0] m_stat(int b);
    logic [31:0] s = '0;
    for (int i = 0; i < 32; i++) if (m_pend(b, i) && m_mask[b][i]) s[i] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    int b = a[3];
    int w = a[2:0];
    logic [31:0] s;
    case (w)
      0: return m_srcq;
      1: return m_mask[b];
      3: return m_mode[b];
      4: return m_sense[b];
      5: return m_stat(b);
      6: begin
        if (b != 0) return 32'h0;
        s = m_stat(0);
        for (int i = 0; i < 32; i++) if (s[i]) return i;
        return 32'h8000_0000;
      end
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step();
    bit nl [2];
    bit prev, now, ev, cl;
    for (int b = 0; b < 2; b++) nl[b] = (m_stat(b) != 0);
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 32; i++) begin
        if (m_mode[b][i]) begin
          prev = m_srcq[i];
          now  = src_in[i];
          ev   = m_sense[b][i] ? (prev && !now) : (!prev && now);
          cl   = bus_wr && (bus_waddr[3] == b[0]) && (bus_waddr[2:0] == 3'd2) && bus_wdata[i];
          if (ev) m_latch[b][i] = 1'b1;
          else if (cl) m_latch[b][i] = 1'b0;
        end else begin
          m_latch[b][i] = 1'b0;
        end
      end
    end
    m_srcq = src_in;
    if (bus_wr) begin
      case (bus_waddr[2:0])
        3'd1: m_mask[bus_waddr[3]]  = bus_wdata;
        3'd3: m_mode[bus_waddr[3]]  = bus_wdata;
        3'd4: m_sense[bus_waddr[3]] = bus_wdata;
        default: ;
      endcase
    end
    m_line[0] = nl[0];
    m_line[1] = nl[1];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_srcq = '0;
      for (int b = 0; b < 2; b++) begin
        m_mask[b] = '0; m_mode[b] = '0; m_sense[b] = '0; m_latch[b] = '0; m_line[b] = 1'b0;
      end
    end else begin
      model_step();
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    #4;
    if (rst_n && !done) begin
      chk("R8 model irq_o", 32'(irq_o), 32'(m_line[0]));
      chk("R8 model fiq_o", 32'(fiq_o), 32'(m_line[1]));
      chk("R2 model read", bus_rdata, m_read(bus_waddr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_waddr = a;
    #0.2;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog got=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 irq_o low", 32'(irq_o), 0);
    chk("R1 fiq_o low", 32'(fiq_o), 0);
    rd(4'd6, d);  chk("R1 first none", d, 32'h8000_0000);
    rd(4'd1, d);  chk("R1 mask zero", d, 0);
    rd(4'd13, d); chk("R1 fast status zero", d, 0);

    // R3 mask readback, R4 level active low
    wr(4'd1, 32'h28);
    rd(4'd1, d);  chk("R3 mask readback", d, 32'h28);
    wr(4'd4, 32'h20);
    rd(4'd5, d);  chk("R4 active-low pending", d, 32'h20);
    rd(4'd6, d);  chk("R10 first is 5", d, 5);
    step(1);
    chk("R8 irq_o raised", 32'(irq_o), 1);

    // R4 active high, R2 raw view
    @(negedge clk); src_in[3] = 1'b1;
    step(1);
    rd(4'd5, d);  chk("R4 active-high pending", d, 32'h28);
    rd(4'd6, d);  chk("R10 first is 3", d, 3);
    rd(4'd0, d);  chk("R2 raw view", d, 32'h08);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd5, d);  chk("R4 clear ignored on level", d, 32'h28);
    @(negedge clk); src_in = 32'h20;
    step(1);
    rd(4'd5, d);  chk("R4 level follows input", d, 0);
    step(1);
    chk("R8 irq_o dropped", 32'(irq_o), 0);

    // R5 rising edge sticky, R6 selective clear
    wr(4'd3, 32'h400);
    wr(4'd1, 32'h400);
    @(negedge clk); src_in[10] = 1'b1;
    @(negedge clk); src_in[10] = 1'b0;
    step(1);
    rd(4'd5, d);  chk("R5 rising edge latched", d, 32'h400);
    chk("R8 irq_o from edge", 32'(irq_o), 1);
    step(3);
    rd(4'd5, d);  chk("R5 pending stays", d, 32'h400);
    wr(4'd2, 32'h8);
    rd(4'd5, d);  chk("R6 other bit clear no effect", d, 32'h400);
    rd(4'd2, d);  chk("R6 clear word reads 0", d, 0);
    wr(4'd2, 32'h400);
    rd(4'd5, d);  chk("R6 clear removes pending", d, 0);
    step(1);
    chk("R8 irq_o after clear", 32'(irq_o), 0);

    // R7 latched while masked
    wr(4'd1, 32'h0);
    @(negedge clk); src_in[10] = 1'b1;
    @(negedge clk); src_in[10] = 1'b0;
    rd(4'd5, d);  chk("R7 masked status empty", d, 0);
    wr(4'd1, 32'h400);
    rd(4'd5, d);  chk("R7 unmask shows latched edge", d, 32'h400);
    wr(4'd2, 32'h400);
    rd(4'd5, d);  chk("R6 cleared again", d, 0);

    // R6 edge and clear in the same cycle: edge wins
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = 4'd2; bus_wdata = 32'h400; src_in[10] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; src_in[10] = 1'b0;
    rd(4'd5, d);  chk("R6 edge beats clear", d, 32'h400);
    wr(4'd2, 32'h400);
    rd(4'd5, d);  chk("R6 final clear", d, 0);

    // R5 falling edge in fast bank, R9 independence
    wr(4'd11, 32'h8000_0000);
    wr(4'd12, 32'h8000_0000);
    wr(4'd9,  32'h8000_0000);
    @(negedge clk); src_in[31] = 1'b1;
    step(1);
    rd(4'd13, d); chk("R5 rising ignored in falling mode", d, 0);
    @(negedge clk); src_in[31] = 1'b0;
    step(1);
    rd(4'd13, d); chk("R5 falling edge latched", d, 32'h8000_0000);
    rd(4'd5, d);  chk("R9 normal bank untouched", d, 0);
    step(1);
    chk("R8 fiq_o raised", 32'(fiq_o), 1);
    chk("R9 irq_o stays low", 32'(irq_o), 0);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd13, d); chk("R9 normal clear spares fast bank", d, 32'h8000_0000);
    wr(4'd10, 32'h8000_0000);
    rd(4'd13, d); chk("R6 fast clear", d, 0);
    step(1);
    chk("R8 fiq_o dropped", 32'(fiq_o), 0);

    // R7 read-only words ignore writes
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd13, 32'hFFFF_FFFF);
    rd(4'd1, d);  chk("R7 mask unchanged", d, 32'h400);
    rd(4'd5, d);  chk("R7 status unchanged", d, 0);
    rd(4'd6, d);  chk("R10 first none after writes", d, 32'h8000_0000);
    rd(4'd14, d); chk("R10 fast 0x38 reads 0", d, 0);
    rd(4'd9, d);  chk("R9 fast mask kept", d, 32'h8000_0000);

    // R10 lowest index across patterns
    wr(4'd1, 32'hFFFF_FFFF);
    @(negedge clk); src_in = 32'h0001_1020;
    step(1);
    rd(4'd6, d);  chk("R10 first is 12", d, 12);
    rd(4'd5, d);  chk("R7 status multi", d, 32'h0001_1000);
    @(negedge clk); src_in = 32'h1000_0020;
    step(1);
    rd(4'd6, d);  chk("R10 first is 28", d, 28);
    @(negedge clk); src_in = 32'h8000_0020;
    step(1);
    rd(4'd6, d);  chk("R10 first is 31", d, 31);
    @(negedge clk); src_in = 32'h21;
    step(1);
    rd(4'd6, d);  chk("R10 first is 0", d, 0);
    @(negedge clk); src_in = 32'h20;
    step(1);
    rd(4'd6, d);  chk("R10 none again", d, 32'h8000_0000);
    step(2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule